// File: doc/BRIEF.md
# Output Buffer Source Arbiter

This block decides which of four producers owns the single byte-wide output buffer that a host reads through the data port. The producers are a controller reply aimed at the keyboard channel, a controller reply aimed at the aux channel, bytes from the keyboard device and bytes from the mouse device. A reply waits in one internal slot. Each device presents its byte on a valid/ready pair and holds it until it is popped. When the buffer is empty and nothing holds it back, the block latches the highest-priority requester. It then raises the buffer-full flags and drives the two interrupt lines.

On a host read the latched source is emptied into the read-data register. For a device source, the device's ready line pulses in the same cycle. An optional hold-off window, set in clock cycles, keeps the buffer from re-arming for a while after a keyboard byte has been read. This paces keystrokes for software that cannot keep up. The mode-byte fields that the block uses arrive as four separate inputs from the command decoder.

Top module: `obuf_arbiter`

## Requirements
- R1: After reset, `obf_o`, `aux_obf_o`, both interrupt lines and both ready lines are low, and `rd_data_o` is 0x00.
- R2: When several sources request at once, a controller reply wins over keyboard data, and keyboard data wins over mouse data. Of the two reply kinds, only the most recently queued one exists.
- R3: Keyboard data is ignored while `kbd_dis_i` (mode bit 4) is 1, and mouse data is ignored while `aux_dis_i` (mode bit 5) is 1. Controller replies are never masked.
- R4: Latching any source sets `obf_o` (status bit 0 and output-port bit 4). Latching an aux reply or mouse data also sets `aux_obf_o` (status bit 5 and output-port bit 5).
- R5: `irq_aux_o` = `obf_o` & `aux_obf_o` & `aux_irq_en_i` (mode bit 1). `irq_kbd_o` = `obf_o` & !`aux_obf_o` & `kbd_irq_en_i` (mode bit 0) & !`kbd_dis_i`.
- R6: A read while `obf_o` is 1 clears both full flags on the next clock and loads `rd_data_o` with the latched source's byte. For a device source, that device's ready line is high during the read cycle, so exactly one byte is popped.
- R7: A read while `obf_o` is 0 changes nothing: `rd_data_o` keeps its value and no device is popped.
- R8: While `obf_o` is 1, a newly arriving request of any priority does not replace the latched source.
- R9: Reading a keyboard-sourced byte blocks arbitration for `THROTTLE_CYCLES` cycles. With a request pending, `obf_o` rises `THROTTLE_CYCLES`+1 cycles after the read edge. A value of 0 removes the window.
- R10: Queuing a controller reply overwrites the single reply slot and its kind. Only the last reply is delivered, and it is delivered once.
- R11: A change of any mode input moves the interrupt lines in the same cycle, without a clock edge, and does not release a latched byte.
- R12: Reading a reply or mouse byte starts no hold-off: a pending request is latched on the very next clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| kbd_irq_en_i | input | 1 | Mode bit 0: keyboard interrupt enable |
| aux_irq_en_i | input | 1 | Mode bit 1: aux interrupt enable |
| kbd_dis_i | input | 1 | Mode bit 4: keyboard interface disabled |
| aux_dis_i | input | 1 | Mode bit 5: aux interface disabled |
| rsp_push_i | input | 1 | Queue a controller reply this cycle |
| rsp_aux_i | input | 1 | Reply kind: 1 aux channel, 0 keyboard channel |
| rsp_byte_i | input | 8 | Reply byte |
| kbd_valid_i | input | 1 | Keyboard device has a byte |
| kbd_data_i | input | 8 | Keyboard device byte |
| kbd_ready_o | output | 1 | Pops the keyboard byte |
| aux_valid_i | input | 1 | Mouse device has a byte |
| aux_data_i | input | 8 | Mouse device byte |
| aux_ready_o | output | 1 | Pops the mouse byte |
| rd_i | input | 1 | Host data-port read strobe |
| rd_data_o | output | 8 | Byte returned by the last effective read |
| obf_o | output | 1 | Output buffer full |
| aux_obf_o | output | 1 | Output buffer holds an aux-channel byte |
| irq_kbd_o | output | 1 | Keyboard interrupt level |
| irq_aux_o | output | 1 | Aux interrupt level |

## Verification
A wrong source latch shows within one read: either `aux_obf_o` has the wrong value while the byte is held, or the byte returned on the next clock is wrong. A ready line that fires on the wrong device leaves a byte stranded or lost, which shows at the following read. A broken hold-off counter moves the cycle at which `obf_o` comes back after a keyboard read, so the bench measures that distance exactly. Mistakes in the interrupt equations show in the very cycle a mode input toggles.

// File: rtl/obuf_arbiter.sv
module obuf_arbiter #(
  parameter int unsigned THROTTLE_CYCLES = 100000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       kbd_irq_en_i,
  input  logic       aux_irq_en_i,
  input  logic       kbd_dis_i,
  input  logic       aux_dis_i,
  input  logic       rsp_push_i,
  input  logic       rsp_aux_i,
  input  logic [7:0] rsp_byte_i,
  input  logic       kbd_valid_i,
  input  logic [7:0] kbd_data_i,
  output logic       kbd_ready_o,
  input  logic       aux_valid_i,
  input  logic [7:0] aux_data_i,
  output logic       aux_ready_o,
  input  logic       rd_i,
  output logic [7:0] rd_data_o,
  output logic       obf_o,
  output logic       aux_obf_o,
  output logic       irq_kbd_o,
  output logic       irq_aux_o
);

  localparam logic [1:0] SRC_CTRL = 2'd0;
  localparam logic [1:0] SRC_KBD  = 2'd1;
  localparam logic [1:0] SRC_AUX  = 2'd2;

  logic       full_q, auxf_q, rsp_kbd_q, rsp_aux_q, held;
  logic [1:0] src_q;
  logic [7:0] slot_q, data_q;

  wire kbd_req = kbd_valid_i & ~kbd_dis_i;
  wire aux_req = aux_valid_i & ~aux_dis_i;
  wire any_req = rsp_kbd_q | rsp_aux_q | kbd_req | aux_req;
  wire take    = rd_i & full_q;
  wire arb     = ~full_q & ~held & any_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q    <= 1'b0;
      auxf_q    <= 1'b0;
      src_q     <= SRC_CTRL;
      rsp_kbd_q <= 1'b0;
      rsp_aux_q <= 1'b0;
      slot_q    <= 8'h00;
      data_q    <= 8'h00;
    end else begin
      if (take) begin
        full_q <= 1'b0;
        auxf_q <= 1'b0;
        case (src_q)
          SRC_KBD: data_q <= kbd_data_i;
          SRC_AUX: data_q <= aux_data_i;
          default: data_q <= slot_q;
        endcase
        if (src_q == SRC_CTRL) begin
          rsp_kbd_q <= 1'b0;
          rsp_aux_q <= 1'b0;
        end
      end else if (arb) begin
        full_q <= 1'b1;
        if (rsp_kbd_q) begin
          src_q  <= SRC_CTRL;
          auxf_q <= 1'b0;
        end else if (rsp_aux_q) begin
          src_q  <= SRC_CTRL;
          auxf_q <= 1'b1;
        end else if (kbd_req) begin
          src_q  <= SRC_KBD;
          auxf_q <= 1'b0;
        end else begin
          src_q  <= SRC_AUX;
          auxf_q <= 1'b1;
        end
      end
      if (rsp_push_i) begin
        slot_q    <= rsp_byte_i;
        rsp_kbd_q <= ~rsp_aux_i;
        rsp_aux_q <= rsp_aux_i;
      end
    end
  end

  generate
    if (THROTTLE_CYCLES == 0) begin : g_no_thr
      assign held = 1'b0;
    end else begin : g_thr
      localparam int CW = $clog2(THROTTLE_CYCLES + 1);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          cnt_q <= '0;
        else if (take && src_q == SRC_KBD)
          cnt_q <= CW'(THROTTLE_CYCLES);
        else if (cnt_q != '0)
          cnt_q <= cnt_q - 1'b1;
      end
      assign held = (cnt_q != '0);
    end
  endgenerate

  assign kbd_ready_o = take & (src_q == SRC_KBD);
  assign aux_ready_o = take & (src_q == SRC_AUX);
  assign rd_data_o   = data_q;
  assign obf_o       = full_q;
  assign aux_obf_o   = auxf_q;
  assign irq_aux_o   = full_q & auxf_q & aux_irq_en_i;
  assign irq_kbd_o   = full_q & ~auxf_q & kbd_irq_en_i & ~kbd_dis_i;

endmodule

// File: rtl/obuf_arbiter_chk.sv
module obuf_arbiter_chk #(
  parameter int unsigned THR = 0
) (
  input logic       clk,
  input logic       rst_n,
  input logic       rd,
  input logic       obf,
  input logic       aux_obf,
  input logic       irq_kbd,
  input logic       irq_aux,
  input logic       kbd_dis,
  input logic       kbd_valid,
  input logic       aux_valid,
  input logic       kbd_ready,
  input logic       aux_ready,
  input logic [7:0] rd_data
);

  int unsigned win_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         win_q <= 0;
    else if (kbd_ready) win_q <= THR;
    else if (win_q != 0) win_q <= win_q - 1;
  end

  assert_auxfull_in_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
    aux_obf |-> obf);
  assert_irq_exclusive_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_kbd && irq_aux));
  assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd && obf |=> !obf && !aux_obf);
  assert_single_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({kbd_ready, aux_ready}));
  assert_pop_has_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (kbd_ready |-> kbd_valid) and (aux_ready |-> aux_valid));
  assert_idle_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd && !obf |=> $stable(rd_data));
  assert_no_pop_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !obf |-> !kbd_ready && !aux_ready);
  assert_hold_latched_R8: assert property (@(posedge clk) disable iff (!rst_n)
    obf && !rd |=> obf && $stable(aux_obf));
  assert_throttle_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
    win_q != 0 |-> !obf);
  assert_kbd_irq_masked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    kbd_dis |-> !irq_kbd);

endmodule

bind obuf_arbiter obuf_arbiter_chk #(.THR(THROTTLE_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd(rd_i), .obf(obf_o), .aux_obf(aux_obf_o),
  .irq_kbd(irq_kbd_o), .irq_aux(irq_aux_o), .kbd_dis(kbd_dis_i),
  .kbd_valid(kbd_valid_i), .aux_valid(aux_valid_i),
  .kbd_ready(kbd_ready_o), .aux_ready(aux_ready_o), .rd_data(rd_data_o)
);

// File: tb/obuf_arbiter_bench.sv
module obuf_arbiter_bench;
  localparam int THR = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic kbd_irq_en = 1'b1, aux_irq_en = 1'b1, kbd_dis = 1'b0, aux_dis = 1'b0;
  logic rsp_push = 1'b0, rsp_aux = 1'b0, rd = 1'b0;
  logic [7:0] rsp_byte = 8'h00;
  logic kbd_valid = 1'b0, aux_valid = 1'b0;
  logic [7:0] kbd_data = 8'h00, aux_data = 8'h00;
  logic kbd_ready, aux_ready, obf, aux_obf, irq_kbd, irq_aux;
  logic [7:0] rd_data;

  obuf_arbiter #(.THROTTLE_CYCLES(THR)) u_obuf_arbiter (
    .clk(clk), .rst_n(rst_n),
    .kbd_irq_en_i(kbd_irq_en), .aux_irq_en_i(aux_irq_en),
    .kbd_dis_i(kbd_dis), .aux_dis_i(aux_dis),
    .rsp_push_i(rsp_push), .rsp_aux_i(rsp_aux), .rsp_byte_i(rsp_byte),
    .kbd_valid_i(kbd_valid), .kbd_data_i(kbd_data), .kbd_ready_o(kbd_ready),
    .aux_valid_i(aux_valid), .aux_data_i(aux_data), .aux_ready_o(aux_ready),
    .rd_i(rd), .rd_data_o(rd_data), .obf_o(obf), .aux_obf_o(aux_obf),
    .irq_kbd_o(irq_kbd), .irq_aux_o(irq_aux)
  );

  int n_vec = 0, n_bad = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] kq[$], aq[$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic refresh();
    kbd_valid = (kq.size() != 0);
    kbd_data  = (kq.size() != 0) ? kq[0] : 8'h00;
    aux_valid = (aq.size() != 0);
    aux_data  = (aq.size() != 0) ? aq[0] : 8'h00;
  endtask

  // device models: pop on ready, after the edge has sampled the data
  always @(posedge clk) begin
    bit pk, pa;
    pk = kbd_ready;
    pa = aux_ready;
    if (pk || pa) begin
      #1;
      if (pk && kq.size() != 0) void'(kq.pop_front());
      if (pa && aq.size() != 0) void'(aq.pop_front());
      refresh();
    end
  end

  // scoreboard monitor
  always @(posedge clk) begin
    bit hit;
    logic [7:0] e;
    string t;
    hit = rd && obf;
    if (hit) begin
      #2;
      if (exp_q.size() == 0) begin
        n_vec++; n_bad++;
        $display("FAIL R6 unexpected read actual=%0h expected=none", rd_data);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(t, rd_data, e);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic kadd(input logic [7:0] b); kq.push_back(b); refresh(); endtask
  task automatic aadd(input logic [7:0] b); aq.push_back(b); refresh(); endtask

  task automatic rsp(input logic [7:0] b, input logic a);
    rsp_push = 1'b1; rsp_byte = b; rsp_aux = a;
    @(negedge clk);
    rsp_push = 1'b0;
  endtask

  task automatic host_rd(input logic [7:0] e, input string t);
    rd = 1'b1;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic wait_obf(output int k);
    k = 0;
    while (!obf && k < 200) begin
      @(negedge clk);
      k++;
    end
  endtask

  bit done = 1'b0;
  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #2000000;
    n_vec++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    int k;
    tick(3);
    rst_n = 1'b1;
    chk("R1 obf", obf, 0);
    chk("R1 aux_obf", aux_obf, 0);
    chk("R1 irq_kbd", irq_kbd, 0);
    chk("R1 irq_aux", irq_aux, 0);
    chk("R1 rd_data", rd_data, 8'h00);
    chk("R1 ready", {kbd_ready, aux_ready}, 0);

    // keyboard byte, then hold-off window
    kadd(8'h1C); kadd(8'h32);
    tick(1);
    chk("R4 kbd obf", obf, 1);
    chk("R4 kbd aux_obf", aux_obf, 0);
    chk("R5 irq_kbd", irq_kbd, 1);
    chk("R5 irq_aux", irq_aux, 0);
    host_rd(8'h1C, "R6 kbd byte");
    chk("R6 obf cleared", obf, 0);
    chk("R6 irq cleared", irq_kbd, 0);
    chk("R6 one pop", kq.size(), 1);
    wait_obf(k);
    chk("R9 throttle distance", k, THR + 1);
    host_rd(8'h32, "R6 second kbd byte");

    // all three request during the window
    kadd(8'hA5); aadd(8'h5A);
    rsp(8'hC3, 1'b0);
    wait_obf(k);
    chk("R2 reply first aux_obf", aux_obf, 0);
    host_rd(8'hC3, "R2 reply byte first");
    wait_obf(k);
    chk("R12 no throttle after reply", k, 1);
    chk("R2 kbd second aux_obf", aux_obf, 0);
    host_rd(8'hA5, "R2 kbd byte second");
    tick(THR + 3);
    chk("R4 mouse aux_obf", aux_obf, 1);
    chk("R5 irq_aux mouse", irq_aux, 1);
    chk("R5 irq_kbd low for aux", irq_kbd, 0);
    host_rd(8'h5A, "R2 mouse byte last");
    tick(2);
    chk("R12 empty after mouse", obf, 0);

    // masking and idle read
    kbd_dis = 1'b1; aux_dis = 1'b1;
    kadd(8'h44); aadd(8'h55);
    tick(4);
    chk("R3 masked devices", obf, 0);
    rd = 1'b1;
    #1;
    chk("R7 no ready on idle read", {kbd_ready, aux_ready}, 0);
    @(negedge clk);
    rd = 1'b0;
    chk("R7 rd_data kept", rd_data, 8'h5A);
    chk("R7 kbd not popped", kq.size(), 1);
    chk("R7 aux not popped", aq.size(), 1);
    rsp(8'hAA, 1'b1);
    tick(1);
    chk("R3 reply unmasked", obf, 1);
    chk("R4 aux reply aux_obf", aux_obf, 1);
    chk("R5 irq_aux reply", irq_aux, 1);
    aux_irq_en = 1'b0;
    #1;
    chk("R11 irq_aux drops", irq_aux, 0);
    aux_irq_en = 1'b1;
    #1;
    chk("R11 irq_aux returns", irq_aux, 1);
    @(negedge clk);
    host_rd(8'hAA, "R3 aux reply byte");
    tick(2);
    chk("R3 still masked", obf, 0);
    kbd_dis = 1'b0;
    tick(1);
    chk("R3 kbd unmasked", obf, 1);
    chk("R5 irq_kbd after unmask", irq_kbd, 1);
    kbd_dis = 1'b1;
    #1;
    chk("R11 irq_kbd drops on disable", irq_kbd, 0);
    chk("R11 byte stays latched", obf, 1);
    kbd_dis = 1'b0;
    @(negedge clk);
    host_rd(8'h44, "R3 kbd byte after unmask");
    aux_dis = 1'b0;
    tick(THR + 3);
    chk("R3 mouse unmasked", aux_obf, 1);

    // busy buffer, reply overwrite
    rsp(8'h11, 1'b0);
    rsp(8'h22, 1'b1);
    tick(2);
    chk("R8 still latched obf", obf, 1);
    chk("R8 still latched aux_obf", aux_obf, 1);
    host_rd(8'h55, "R8 latched mouse byte");
    tick(1);
    chk("R10 last reply kind", aux_obf, 1);
    host_rd(8'h22, "R10 last reply byte");
    tick(3);
    chk("R10 single delivery", obf, 0);
    chk("R6 scoreboard drained", exp_q.size(), 0);
    chk("R6 devices drained", kq.size() + aq.size(), 0);
    finish_run();
  end
endmodule